// File: doc/BRIEF.md
# Sparse Command Sequencer for a Sponge Hash Engine

This block sits between software and a sponge-construction hash engine. Software issues commands as 6-bit codewords together with a one-cycle strobe. The sequencer checks each codeword and, if it fits the current phase, moves the engine through its phases. The engine is started, its message is absorbed, it squeezes out extra blocks on request, and it is finally cleared back to rest. The engine reports each finished permutation on a single completion input. The sequencer turns that report into a hash-done pulse after absorption, or into a return to squeezing after an extra squeeze.

The hash mode and the strength code are checked when the start command arrives. A combination that is not allowed refuses the start. An accepted start captures the sponge rate and the padding suffix that the datapath needs. Those captured values, and the configuration write-enable, stay frozen until the operation ends. Three kinds of software fault are reported as errors: an unknown codeword, a command in the wrong phase and a refused configuration. A phase error parks the sequencer in an error phase until software acknowledges it. The phase register uses a sparse code, so a corrupted value falls into a terminal fatal phase.

Phases and transitions:
- IDLE goes to ABSORB on an accepted start.
- ABSORB goes to PADWAIT on process.
- PADWAIT goes to SQUEEZE on engine completion.
- SQUEEZE goes to RUNWAIT on run, and to IDLE on done.
- RUNWAIT goes back to SQUEEZE on engine completion.
- Any phase except ERROR and FATAL goes to ERROR on a wrong-phase command or a refused start.
- ERROR goes to IDLE on the acknowledge input.
- An invalid phase code goes to FATAL, and FATAL is never left.

Top module: `spx_cmd_seq`

## Requirements
- R1: A command is taken only when `cmd_valid` is 1. The codewords are start = 6'b011101, process = 6'b101110, run = 6'b110001 and done = 6'b010110. While `cmd_valid` is 0, `cmd_code` has no effect.
- R2: Start in IDLE moves to ABSORB and pulses `eng_start` for one cycle, in the cycle after the command. Process in ABSORB moves to PADWAIT and pulses `eng_process`. Then `perm_done` moves to SQUEEZE and pulses `hash_done`.
- R3: A legal codeword that does not fit the current phase moves to ERROR and pulses `err_pulse`. It sets `err_code` to 2 and issues no engine pulse.
- R4: Run is honoured only in SQUEEZE. It pulses `eng_run` and moves to RUNWAIT, and `perm_done` there returns to SQUEEZE. Run may be repeated any number of times, and run in ABSORB or PADWAIT is a phase error.
- R5: Done in SQUEEZE returns to IDLE and pulses `eng_clear`. It also clears the captured rate and suffix to 0.
- R6: A start is accepted only in these cases:
  - mode 0 (SHA3) with strength 0 to 4;
  - mode 2 (SHAKE) or mode 3 (cSHAKE) with strength 0 or 2;
  - mode 2 or mode 3 with strength 0 to 4 when `cfg_allow_any` is 1.

  Mode 1 and strengths 5 to 7 are always refused. A refused start moves to ERROR with `err_code` 3 and no `eng_start`.
- R7: An accepted start captures `rate_bits`. Strength 0, 1, 2, 3 and 4 give 1344, 1152, 1088, 832 and 576.
- R8: An accepted start captures the padding suffix as a right-aligned value with a length. SHA3 gives value 2'b10 with length 2, SHAKE gives 4'b1111 with length 4, and cSHAKE gives 2'b00 with length 2.
- R9: `cfg_wen` is 1 only in IDLE. While it is 0, changes on the configuration inputs leave `rate_bits`, `pad_suffix` and `pad_len` unchanged.
- R10: `st_idle` is 1 in IDLE and is 1 out of reset. `st_absorb` is 1 in ABSORB and PADWAIT. `st_squeeze` is 1 in SQUEEZE and RUNWAIT. All three are 0 in ERROR.
- R11: ERROR is held until `err_ack` is 1. While in ERROR, all commands and `perm_done` are ignored. The acknowledge returns to IDLE, pulses `eng_clear` and sets `err_code` to 0. In any other non-fatal phase, `err_ack` clears `err_code` and nothing else.
- R12: With `cmd_valid` 1, a code that is none of the four codewords pulses `err_pulse` and sets `err_code` to 1. It does not change the phase. In ERROR it is ignored.
- R13: The phase register uses a distance-3 sparse code. Any code outside it enters FATAL, which is never left and drives `fatal` to 1. `fatal` is 0 in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 6 | Sparse command codeword |
| cfg_mode | input | 2 | Hash mode code |
| cfg_strength | input | 3 | Strength code |
| cfg_allow_any | input | 1 | Permit any strength 0 to 4 for SHAKE and cSHAKE |
| err_ack | input | 1 | Software has processed the error |
| perm_done | input | 1 | Engine finished its permutation |
| eng_start | output | 1 | Start pulse to the engine |
| eng_process | output | 1 | Process (pad and finish absorbing) pulse |
| eng_run | output | 1 | Extra squeeze permutation pulse |
| eng_clear | output | 1 | Clear engine state pulse |
| hash_done | output | 1 | Absorption completed pulse |
| err_pulse | output | 1 | One-cycle error event |
| err_code | output | 3 | 0 none, 1 unknown code, 2 wrong phase, 3 refused config |
| st_idle | output | 1 | Idle status |
| st_absorb | output | 1 | Absorb status |
| st_squeeze | output | 1 | Squeeze status |
| cfg_wen | output | 1 | Configuration write-enable |
| fatal | output | 1 | Terminal fault indicator |
| rate_bits | output | 11 | Captured sponge rate in bits |
| pad_suffix | output | 4 | Captured padding suffix, right aligned |
| pad_len | output | 3 | Length of the padding suffix in bits |

## Verification
The bench builds the block with its default widths: a 3-bit strength field, a 2-bit mode field and an 11-bit rate. At these widths every mode and strength code can be applied, including the undefined mode 1 and strengths 5 to 7, each with the override both off and on. A behavioural model tracks the phase, the error code and the captured rate and suffix, and is compared with the outputs on every clock. The stimulus covers the full start–process–run–done flow with repeated runs, every wrong-phase command and unknown codewords in several phases. It also changes the configuration while busy.

// File: rtl/spx_seq_pkg.sv
package spx_seq_pkg;

    localparam int CMD_W = 6;

    localparam logic [CMD_W-1:0] CODE_START   = 6'b011101;
    localparam logic [CMD_W-1:0] CODE_PROCESS = 6'b101110;
    localparam logic [CMD_W-1:0] CODE_RUN     = 6'b110001;
    localparam logic [CMD_W-1:0] CODE_DONE    = 6'b010110;

    localparam logic [1:0] MODE_SHA3   = 2'd0;
    localparam logic [1:0] MODE_SHAKE  = 2'd2;
    localparam logic [1:0] MODE_CSHAKE = 2'd3;

    // Phase codes form a shortened Hamming code: minimum distance 3.
    typedef enum logic [5:0] {
        ST_IDLE     = 6'b001011,
        ST_ABSORB   = 6'b010101,
        ST_PADWAIT  = 6'b100110,
        ST_SQUEEZE  = 6'b111000,
        ST_RUNWAIT  = 6'b011110,
        ST_ERROR    = 6'b110011,
        ST_FATAL    = 6'b101101
    } phase_e;

    typedef enum logic [2:0] {
        CK_NONE, CK_START, CK_PROCESS, CK_RUN, CK_DONE, CK_BAD
    } cmd_kind_e;

    typedef enum logic [2:0] {
        EC_NONE      = 3'd0,
        EC_BAD_CODE  = 3'd1,
        EC_BAD_ORDER = 3'd2,
        EC_BAD_CFG   = 3'd3
    } err_e;

    // Security strength in bits for each strength code.
    function automatic int strength_bits(input int idx);
        case (idx)
            0:       return 128;
            1:       return 224;
            2:       return 256;
            3:       return 384;
            default: return 512;
        endcase
    endfunction

    // Sponge rate: the 1600-bit state minus twice the strength.
    function automatic int rate_of(input int idx);
        return 1600 - 2 * strength_bits(idx);
    endfunction

endpackage

// File: rtl/spx_cmd_decode.sv
module spx_cmd_decode
    import spx_seq_pkg::*;
#(
    parameter int CODE_W = CMD_W
) (
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    output cmd_kind_e         kind
);

    always_comb begin
        kind = CK_NONE;
        if (valid) begin
            unique case (code)
                CODE_START:   kind = CK_START;
                CODE_PROCESS: kind = CK_PROCESS;
                CODE_RUN:     kind = CK_RUN;
                CODE_DONE:    kind = CK_DONE;
                default:      kind = CK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/spx_cfg_check.sv
module spx_cfg_check
    import spx_seq_pkg::*;
#(
    parameter int MODE_W  = 2,
    parameter int STR_W   = 3,
    parameter int RATE_W  = 11,
    parameter int SUF_W   = 4,
    parameter int LEN_W   = 3,
    parameter int NUM_STR = 5
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [STR_W-1:0]  strength,
    input  logic              allow_any,
    output logic              cfg_ok,
    output logic [RATE_W-1:0] rate,
    output logic [SUF_W-1:0]  suffix,
    output logic [LEN_W-1:0]  suffix_len
);

    logic [RATE_W-1:0] rate_tbl [NUM_STR];

    for (genvar gi = 0; gi < NUM_STR; gi++) begin : g_rate
        assign rate_tbl[gi] = RATE_W'(rate_of(gi));
    end

    logic in_range;
    logic xof_strength;

    assign in_range     = (strength < STR_W'(NUM_STR));
    assign xof_strength = (strength == STR_W'(0)) || (strength == STR_W'(2));

    always_comb begin
        rate = '0;
        for (int i = 0; i < NUM_STR; i++) begin
            if (strength == STR_W'(i)) rate = rate_tbl[i];
        end
    end

    always_comb begin
        cfg_ok     = 1'b0;
        suffix     = '0;
        suffix_len = '0;
        unique case (mode)
            MODE_W'(MODE_SHA3): begin
                cfg_ok     = in_range;
                suffix     = SUF_W'(2'b10);
                suffix_len = LEN_W'(2);
            end
            MODE_W'(MODE_SHAKE): begin
                cfg_ok     = in_range && (xof_strength || allow_any);
                suffix     = SUF_W'(4'b1111);
                suffix_len = LEN_W'(4);
            end
            MODE_W'(MODE_CSHAKE): begin
                cfg_ok     = in_range && (xof_strength || allow_any);
                suffix     = SUF_W'(2'b00);
                suffix_len = LEN_W'(2);
            end
            default: begin
                cfg_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spx_phase_fsm.sv
module spx_phase_fsm
    import spx_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_e kind,
    input  logic      cfg_ok,
    input  logic      perm_done,
    input  logic      err_ack,
    output phase_e    state,
    output logic      take_cfg,
    output logic      drop_cfg,
    output logic      start_q,
    output logic      process_q,
    output logic      run_q,
    output logic      clear_q,
    output logic      hdone_q,
    output logic      err_q,
    output err_e      ecode_q
);

    phase_e state_q, state_d;
    logic   start_d, process_d, run_d, clear_d, hdone_d, err_d;
    err_e   ecode_d;
    logic   is_cmd, known;

    assign is_cmd = (kind == CK_START) || (kind == CK_PROCESS) ||
                    (kind == CK_RUN)   || (kind == CK_DONE);
    assign known  = (state_q == ST_IDLE)    || (state_q == ST_ABSORB)  ||
                    (state_q == ST_PADWAIT) || (state_q == ST_SQUEEZE) ||
                    (state_q == ST_RUNWAIT) || (state_q == ST_ERROR)   ||
                    (state_q == ST_FATAL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and event decisions
    always_comb begin
        state_d   = state_q;
        start_d   = 1'b0;
        process_d = 1'b0;
        run_d     = 1'b0;
        clear_d   = 1'b0;
        hdone_d   = 1'b0;
        err_d     = 1'b0;
        ecode_d   = EC_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (kind == CK_START) begin
                    if (cfg_ok) begin
                        state_d = ST_ABSORB;
                        start_d = 1'b1;
                    end else begin
                        state_d = ST_ERROR;
                        err_d   = 1'b1;
                        ecode_d = EC_BAD_CFG;
                    end
                end else if (is_cmd) begin
                    state_d = ST_ERROR;
                    err_d   = 1'b1;
                    ecode_d = EC_BAD_ORDER;
                end
            end
            ST_ABSORB: begin
                if (kind == CK_PROCESS) begin
                    state_d   = ST_PADWAIT;
                    process_d = 1'b1;
                end else if (is_cmd) begin
                    state_d = ST_ERROR;
                    err_d   = 1'b1;
                    ecode_d = EC_BAD_ORDER;
                end
            end
            ST_PADWAIT: begin
                if (is_cmd) begin
                    state_d = ST_ERROR;
                    err_d   = 1'b1;
                    ecode_d = EC_BAD_ORDER;
                end else if (perm_done) begin
                    state_d = ST_SQUEEZE;
                    hdone_d = 1'b1;
                end
            end
            ST_SQUEEZE: begin
                if (kind == CK_RUN) begin
                    state_d = ST_RUNWAIT;
                    run_d   = 1'b1;
                end else if (kind == CK_DONE) begin
                    state_d = ST_IDLE;
                    clear_d = 1'b1;
                end else if (is_cmd) begin
                    state_d = ST_ERROR;
                    err_d   = 1'b1;
                    ecode_d = EC_BAD_ORDER;
                end
            end
            ST_RUNWAIT: begin
                if (is_cmd) begin
                    state_d = ST_ERROR;
                    err_d   = 1'b1;
                    ecode_d = EC_BAD_ORDER;
                end else if (perm_done) begin
                    state_d = ST_SQUEEZE;
                end
            end
            ST_ERROR: begin
                if (err_ack) begin
                    state_d = ST_IDLE;
                    clear_d = 1'b1;
                end
            end
            ST_FATAL: begin
                state_d = ST_FATAL;
            end
            default: begin
                state_d = ST_FATAL;
            end
        endcase
        // Unknown codeword: flag it, keep the phase.
        if (kind == CK_BAD && known && state_q != ST_ERROR && state_q != ST_FATAL) begin
            err_d   = 1'b1;
            ecode_d = EC_BAD_CODE;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            process_q <= 1'b0;
            run_q     <= 1'b0;
            clear_q   <= 1'b0;
            hdone_q   <= 1'b0;
            err_q     <= 1'b0;
            ecode_q   <= EC_NONE;
        end else begin
            start_q   <= start_d;
            process_q <= process_d;
            run_q     <= run_d;
            clear_q   <= clear_d;
            hdone_q   <= hdone_d;
            err_q     <= err_d;
            if (err_d)
                ecode_q <= ecode_d;
            else if (err_ack && state_q != ST_FATAL)
                ecode_q <= EC_NONE;
        end
    end

    assign state    = state_q;
    assign take_cfg = start_d;
    assign drop_cfg = clear_d;

    // R2: the engine is started only from the idle phase
    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> ($past(state_q) == ST_IDLE && state_q == ST_ABSORB));

    // R4: an extra squeeze only leaves the squeeze phase
    p_run_in_squeeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> ($past(state_q) == ST_SQUEEZE && state_q == ST_RUNWAIT));

    // R6: a refused configuration never starts the engine
    p_bad_cfg_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && kind == CK_START && !cfg_ok) |=> (!start_q && state_q == ST_ERROR));

    // R11: the error phase is held until acknowledged
    p_error_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERROR && !err_ack) |=> state_q == ST_ERROR);

    // R12: an unknown codeword keeps the phase
    p_bad_code_keeps_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CK_BAD && known && !perm_done && !err_ack) |=> $stable(state_q));

    // R13: the fatal phase is terminal
    p_fatal_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FATAL |=> state_q == ST_FATAL);

endmodule

// File: rtl/spx_cmd_seq.sv
module spx_cmd_seq
    import spx_seq_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int STR_W  = 3,
    parameter int RATE_W = 11,
    parameter int SUF_W  = 4,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [5:0]        cmd_code,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [STR_W-1:0]  cfg_strength,
    input  logic              cfg_allow_any,
    input  logic              err_ack,
    input  logic              perm_done,
    output logic              eng_start,
    output logic              eng_process,
    output logic              eng_run,
    output logic              eng_clear,
    output logic              hash_done,
    output logic              err_pulse,
    output logic [2:0]        err_code,
    output logic              st_idle,
    output logic              st_absorb,
    output logic              st_squeeze,
    output logic              cfg_wen,
    output logic              fatal,
    output logic [RATE_W-1:0] rate_bits,
    output logic [SUF_W-1:0]  pad_suffix,
    output logic [LEN_W-1:0]  pad_len
);

    cmd_kind_e         kind;
    logic              cfg_ok;
    logic [RATE_W-1:0] rate_w;
    logic [SUF_W-1:0]  suf_w;
    logic [LEN_W-1:0]  len_w;
    phase_e            phase;
    logic              take_cfg, drop_cfg;
    err_e              ecode;

    spx_cmd_decode #(.CODE_W(CMD_W)) u_dec (
        .valid (cmd_valid),
        .code  (cmd_code),
        .kind  (kind)
    );

    spx_cfg_check #(
        .MODE_W (MODE_W),
        .STR_W  (STR_W),
        .RATE_W (RATE_W),
        .SUF_W  (SUF_W),
        .LEN_W  (LEN_W)
    ) u_cfg (
        .mode       (cfg_mode),
        .strength   (cfg_strength),
        .allow_any  (cfg_allow_any),
        .cfg_ok     (cfg_ok),
        .rate       (rate_w),
        .suffix     (suf_w),
        .suffix_len (len_w)
    );

    spx_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .cfg_ok    (cfg_ok),
        .perm_done (perm_done),
        .err_ack   (err_ack),
        .state     (phase),
        .take_cfg  (take_cfg),
        .drop_cfg  (drop_cfg),
        .start_q   (eng_start),
        .process_q (eng_process),
        .run_q     (eng_run),
        .clear_q   (eng_clear),
        .hdone_q   (hash_done),
        .err_q     (err_pulse),
        .ecode_q   (ecode)
    );

    // Captured operation parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_bits  <= '0;
            pad_suffix <= '0;
            pad_len    <= '0;
        end else if (take_cfg) begin
            rate_bits  <= rate_w;
            pad_suffix <= suf_w;
            pad_len    <= len_w;
        end else if (drop_cfg) begin
            rate_bits  <= '0;
            pad_suffix <= '0;
            pad_len    <= '0;
        end
    end

    assign err_code   = ecode;
    assign st_idle    = (phase == ST_IDLE);
    assign st_absorb  = (phase == ST_ABSORB) || (phase == ST_PADWAIT);
    assign st_squeeze = (phase == ST_SQUEEZE) || (phase == ST_RUNWAIT);
    assign cfg_wen    = (phase == ST_IDLE);
    assign fatal      = (phase == ST_FATAL);

    // R9: captured values are frozen while configuration is locked
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cfg_wen) && !cfg_wen) |-> ($stable(rate_bits) && $stable(pad_suffix) && $stable(pad_len)));

    // R10: at most one phase status bit is raised
    p_status_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_idle, st_absorb, st_squeeze}));

endmodule

// File: tb/spx_cmd_seq_tb_top.sv
module spx_cmd_seq_tb_top;

    localparam bit [5:0] C_START = 6'b011101;
    localparam bit [5:0] C_PROC  = 6'b101110;
    localparam bit [5:0] C_RUN   = 6'b110001;
    localparam bit [5:0] C_DONE  = 6'b010110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [5:0] cmd_code = '0;
    logic [1:0] cfg_mode = '0;
    logic [2:0] cfg_strength = '0;
    logic       cfg_allow_any = 1'b0;
    logic       err_ack = 1'b0;
    logic       perm_done = 1'b0;
    logic       eng_start, eng_process, eng_run, eng_clear, hash_done, err_pulse;
    logic [2:0] err_code;
    logic       st_idle, st_absorb, st_squeeze, cfg_wen, fatal;
    logic [10:0] rate_bits;
    logic [3:0] pad_suffix;
    logic [2:0] pad_len;

    always #5 clk = ~clk;

    spx_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cfg_mode(cfg_mode), .cfg_strength(cfg_strength), .cfg_allow_any(cfg_allow_any),
        .err_ack(err_ack), .perm_done(perm_done),
        .eng_start(eng_start), .eng_process(eng_process), .eng_run(eng_run),
        .eng_clear(eng_clear), .hash_done(hash_done), .err_pulse(err_pulse),
        .err_code(err_code), .st_idle(st_idle), .st_absorb(st_absorb),
        .st_squeeze(st_squeeze), .cfg_wen(cfg_wen), .fatal(fatal),
        .rate_bits(rate_bits), .pad_suffix(pad_suffix), .pad_len(pad_len)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Model: 0 idle, 1 absorb, 2 padwait, 3 squeeze, 4 runwait, 5 error
    int m_st = 0, m_ec = 0, m_rate = 0, m_suf = 0, m_len = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit model_ok(input int md, input int s, input bit any);
        if (s > 4) return 0;
        if (md == 0) return 1;
        if (md == 2 || md == 3) return any || s == 0 || s == 2;
        return 0;
    endfunction

    function automatic int model_rate(input int s);
        case (s)
            0: return 1344;
            1: return 1152;
            2: return 1088;
            3: return 832;
            default: return 576;
        endcase
    endfunction

    task automatic cyc(input bit v, input bit [5:0] c, input bit ack, input bit pd, input string req);
        bit e_start = 0, e_proc = 0, e_run = 0, e_clr = 0, e_hd = 0, e_err = 0;
        bit is_cmd, bad, take = 0;
        int nst, nec;
        @(negedge clk);
        cmd_valid = v; cmd_code = c; err_ack = ack; perm_done = pd;
        is_cmd = v && (c == C_START || c == C_PROC || c == C_RUN || c == C_DONE);
        bad    = v && !is_cmd;
        nst = m_st; nec = m_ec;
        case (m_st)
            0: if (is_cmd && c == C_START) begin
                   if (model_ok(cfg_mode, cfg_strength, cfg_allow_any)) begin nst = 1; e_start = 1; take = 1; end
                   else begin nst = 5; e_err = 1; nec = 3; end
               end else if (is_cmd) begin nst = 5; e_err = 1; nec = 2; end
            1: if (is_cmd && c == C_PROC) begin nst = 2; e_proc = 1; end
               else if (is_cmd) begin nst = 5; e_err = 1; nec = 2; end
            2: if (is_cmd) begin nst = 5; e_err = 1; nec = 2; end
               else if (pd) begin nst = 3; e_hd = 1; end
            3: if (is_cmd && c == C_RUN) begin nst = 4; e_run = 1; end
               else if (is_cmd && c == C_DONE) begin nst = 0; e_clr = 1; end
               else if (is_cmd) begin nst = 5; e_err = 1; nec = 2; end
            4: if (is_cmd) begin nst = 5; e_err = 1; nec = 2; end
               else if (pd) nst = 3;
            default: if (ack) begin nst = 0; e_clr = 1; end
        endcase
        if (bad && m_st != 5) begin e_err = 1; nec = 1; end
        if (!e_err && ack) nec = 0;
        @(posedge clk);
        #1;
        m_st = nst; m_ec = nec;
        if (take) begin
            m_rate = model_rate(cfg_strength);
            m_suf  = (cfg_mode == 0) ? 2 : (cfg_mode == 2) ? 15 : 0;
            m_len  = (cfg_mode == 2) ? 4 : 2;
        end else if (e_clr) begin
            m_rate = 0; m_suf = 0; m_len = 0;
        end
        chk(req, "eng_start", eng_start, e_start);
        chk(req, "eng_process", eng_process, e_proc);
        chk(req, "eng_run", eng_run, e_run);
        chk(req, "eng_clear", eng_clear, e_clr);
        chk(req, "hash_done", hash_done, e_hd);
        chk(req, "err_pulse", err_pulse, e_err);
        chk(req, "err_code", err_code, m_ec);
        chk("R10", "st_idle", st_idle, m_st == 0);
        chk("R10", "st_absorb", st_absorb, m_st == 1 || m_st == 2);
        chk("R10", "st_squeeze", st_squeeze, m_st == 3 || m_st == 4);
        chk("R9", "cfg_wen", cfg_wen, m_st == 0);
        chk("R7", "rate_bits", rate_bits, m_rate);
        chk("R8", "pad_suffix", pad_suffix, m_suf);
        chk("R8", "pad_len", pad_len, m_len);
        chk("R13", "fatal", fatal, 0);
    endtask

    task automatic idle_cyc(input string req);
        cyc(0, 6'h00, 0, 0, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", "reset st_idle", st_idle, 1);
        chk("R9", "reset cfg_wen", cfg_wen, 1);
        chk("R10", "reset err_code", err_code, 0);
        idle_cyc("R10");

        // R1: codeword without strobe does nothing
        cyc(0, C_START, 0, 0, "R1");
        cyc(0, C_PROC, 0, 0, "R1");

        // R2 R4 R5: full flow, SHA3 strength 2
        cfg_mode = 2'd0; cfg_strength = 3'd2;
        cyc(1, C_START, 0, 0, "R2");
        cfg_mode = 2'd2; cfg_strength = 3'd4;   // R9: busy, changes ignored
        idle_cyc("R9");
        cyc(0, 6'h00, 0, 1, "R2");              // perm_done in absorb ignored
        cyc(1, C_PROC, 0, 0, "R2");
        idle_cyc("R2");
        cyc(0, 6'h00, 0, 1, "R2");
        cyc(1, C_RUN, 0, 0, "R4");
        idle_cyc("R4");
        cyc(0, 6'h00, 0, 1, "R4");
        cyc(1, C_RUN, 0, 0, "R4");
        cyc(0, 6'h00, 0, 1, "R4");
        cyc(1, C_DONE, 0, 0, "R5");
        idle_cyc("R5");

        // R6 R7 R8: every mode/strength/override combination
        for (int md = 0; md < 4; md++) begin
            for (int s = 0; s < 8; s++) begin
                for (int a = 0; a < 2; a++) begin
                    cfg_mode = md[1:0]; cfg_strength = s[2:0]; cfg_allow_any = a[0];
                    cyc(1, C_START, 0, 0, "R6");
                    cyc(1, C_PROC, 0, 0, "R7");
                    cyc(0, 6'h00, 0, 1, "R8");
                    cyc(1, C_DONE, 0, 0, "R5");
                    cyc(0, 6'h00, 1, 0, "R11");
                end
            end
        end
        cfg_mode = 2'd3; cfg_strength = 3'd0; cfg_allow_any = 1'b0;

        // R3: wrong-phase commands
        cyc(1, C_PROC, 0, 0, "R3");
        cyc(1, C_START, 0, 0, "R11");           // ignored in error
        cyc(0, 6'h00, 0, 1, "R11");
        cyc(1, 6'h3f, 0, 0, "R11");             // bad code ignored in error
        cyc(0, 6'h00, 1, 0, "R11");
        cyc(1, C_RUN, 0, 0, "R3");
        cyc(0, 6'h00, 1, 0, "R11");
        cyc(1, C_START, 0, 0, "R2");
        cyc(1, C_RUN, 0, 0, "R4");              // run during absorb
        cyc(0, 6'h00, 1, 0, "R11");
        cyc(1, C_START, 0, 0, "R2");
        cyc(1, C_PROC, 0, 0, "R2");
        cyc(1, C_DONE, 0, 0, "R3");             // done during padwait
        cyc(0, 6'h00, 1, 0, "R11");
        cyc(1, C_START, 0, 0, "R2");
        cyc(1, C_PROC, 0, 0, "R2");
        cyc(0, 6'h00, 0, 1, "R2");
        cyc(1, C_RUN, 0, 0, "R4");
        cyc(1, C_PROC, 0, 0, "R3");             // command during runwait
        cyc(0, 6'h00, 1, 0, "R11");

        // R12: unknown codewords keep the phase
        cyc(1, 6'h00, 0, 0, "R12");
        cyc(0, 6'h00, 1, 0, "R12");
        cyc(1, C_START, 0, 0, "R2");
        cyc(1, 6'h3f, 0, 0, "R12");
        idle_cyc("R12");
        cyc(1, 6'b011100, 0, 0, "R12");
        cyc(0, 6'h00, 1, 0, "R12");
        cyc(1, C_PROC, 0, 0, "R2");
        cyc(0, 6'h00, 0, 1, "R2");
        cyc(1, 6'b110000, 0, 0, "R12");
        cyc(1, C_DONE, 0, 0, "R5");
        cyc(0, 6'h00, 1, 0, "R12");
        idle_cyc("R13");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule